// File: doc/BRIEF.md
# 8-bit PWM Timer with Overflow and Compare Flags

The block is an 8-bit counter with three behaviours. In plain counting mode it counts up and wraps. In single-slope PWM mode it counts up and wraps, and the output is set at zero and released at the compare value. In dual-slope PWM mode it runs up to 0xFF and back down to 0x00, and the output changes at the compare value on the way up and again on the way down. The counter moves only on cycles where the external clock-enable tick is high. A prescaler outside the block produces that tick.

Software reaches the block through a simple write port with four addresses: control, counter, compare value and flag clear. There are two flags, overflow and compare match. Each flag has an enable, and one global enable gates both. An interrupt line stays high while its flag is set and both enables are on. In the PWM modes the compare value is double-buffered, so a new duty cycle starts only at the turning point of the count. A compare value of 0x00 or 0xFF holds the PWM output at a steady level.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the counter is 0x00, both flags and both interrupt lines are 0, and the PWM output is 0.
- R2: The counter changes only on a cycle with the tick high. In plain mode (control bits [1:0] = 00 or 11) and in single-slope mode (10), each tick adds one and 0xFF steps to 0x00. That step sets the overflow flag.
- R3: In dual-slope mode (control bits [1:0] = 01), the count turns from 0xFF to 0xFE and from 0x00 to 0x01. The overflow flag is set by the tick that moves the count away from 0x00. Turning at 0xFF does not set it.
- R4: The compare flag is set by any tick whose new counter value equals the active compare value.
- R5: In plain mode the output field (control bits [3:2]) acts on a compare match: 01 toggles the output, 10 clears it and 11 sets it. With 00 the output is held at 0.
- R6: In single-slope mode with the output field at 10 (non-inverting), the output goes high when the count reaches 0x00 and low on a compare match. With 11 (inverting) the levels are swapped.
- R7: In dual-slope mode with the output field at 10, a match while counting up drives the output low and a match while counting down drives it high. With 11 the levels are swapped. In either PWM mode, an output field of 00 or 01 holds the output at 0.
- R8: In a PWM mode with output field 1x, an active compare value of 0xFF holds the output high (10) or low (11). An active compare value of 0x00 holds it low (10) or high (11). The steady level appears on the cycle after the condition holds.
- R9: In plain mode, a write to the compare address (2) takes effect at once. In a PWM mode, the written value is held and becomes active on the tick that leaves count 0xFF.
- R10: Writing 1 to bit 0 (overflow) or bit 1 (compare) at address 3 clears that flag, and so does a high acknowledge input. A set event in the same cycle wins over the clear.
- R11: The overflow interrupt line equals overflow flag AND control bit 4 AND control bit 6. The compare interrupt line equals compare flag AND control bit 5 AND control bit 6.
- R12: A write to address 1 loads the counter on the next edge and overrides a tick in the same cycle. The control register is written at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-enable tick that advances the counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counter, 2 compare, 3 flag clear |
| wr_data | input | 8 | Write data |
| ack_ovf | input | 1 | Overflow interrupt acknowledge; clears the overflow flag |
| ack_cmp | input | 1 | Compare interrupt acknowledge; clears the compare flag |
| count | output | 8 | Current counter value |
| pwm_out | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
Each write and each tick is taken at one clock edge, and the counter, the flags and the waveform output are all updated at that same edge. The result of a stimulus is therefore visible one cycle later. The interrupt lines follow their flags and enables with no added delay. A steady-level override shows up one cycle after the active compare value and the control bits select it. The bench drives inputs shortly after a rising edge and keeps them for exactly one edge. It reads results shortly after the following edge, so each check falls in the cycle where the value is due.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_DUAL  = 2'b01,
    MODE_SLOPE = 2'b10,
    MODE_SPARE = 2'b11
  } mode_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CNT  = 2'd1;
  localparam logic [1:0] ADR_OCR  = 2'd2;
  localparam logic [1:0] ADR_FLAG = 2'd3;

  localparam int NUM_FLAGS = 2;
  localparam int FLG_OVF   = 0;
  localparam int FLG_CMP   = 1;
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         dual,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         step_up,
  output logic         adv,
  output logic         top_ev,
  output logic         bot_ev
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic dir_up_q;
  logic at_top, at_bot;

  assign at_top = (cnt == TOP);
  assign at_bot = (cnt == '0);
  assign adv    = tick && !ld;
  assign top_ev = adv && at_top;
  assign bot_ev = adv && at_bot;

  always_comb begin
    if (dual) step_up = dir_up_q ? !at_top : at_bot;
    else      step_up = 1'b1;
    cnt_nxt = step_up ? cnt + 1'b1 : cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_up_q <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (tick) begin
      cnt      <= cnt_nxt;
      dir_up_q <= step_up;
    end
  end
endmodule

// File: rtl/pwmt_compare.sv
module pwmt_compare
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [1:0]   com,
  input  logic         wr_ocr,
  input  logic [W-1:0] wr_val,
  input  logic         adv,
  input  logic         top_ev,
  input  logic         step_up,
  input  logic [W-1:0] cnt_nxt,
  output logic [W-1:0] ocr_act,
  output logic         match,
  output logic         pwm_out
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] ocr_buf;
  logic         pwm_mode, steady, steady_lvl;

  assign pwm_mode   = (mode == MODE_DUAL) || (mode == MODE_SLOPE);
  assign match      = adv && (cnt_nxt == ocr_act);
  assign steady     = pwm_mode && com[1] && ((ocr_act == '0) || (ocr_act == TOP));
  assign steady_lvl = (ocr_act == TOP) ^ com[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (wr_ocr) ocr_buf <= wr_val;
      if (wr_ocr && !pwm_mode)   ocr_act <= wr_val;
      else if (pwm_mode && top_ev) ocr_act <= ocr_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
    end else if (com == 2'b00 || (pwm_mode && com == 2'b01)) begin
      pwm_out <= 1'b0;
    end else if (steady) begin
      pwm_out <= steady_lvl;
    end else begin
      unique case (mode)
        MODE_SLOPE: begin
          if (match)                     pwm_out <= com[0];
          else if (adv && cnt_nxt == '0) pwm_out <= ~com[0];
        end
        MODE_DUAL: begin
          if (match) pwm_out <= step_up ? com[0] : ~com[0];
        end
        default: begin
          if (match) begin
            unique case (com)
              2'b01:   pwm_out <= ~pwm_out;
              2'b10:   pwm_out <= 1'b0;
              default: pwm_out <= 1'b1;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pwmt_flags.sv
module pwmt_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_wr,
  input  logic [N-1:0] ack,
  input  logic [N-1:0] ie,
  input  logic         gie,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                     flag[i] <= 1'b0;
      else if (set_ev[i])          flag[i] <= 1'b1;
      else if (clr_wr[i] || ack[i]) flag[i] <= 1'b0;
    end
    assign irq[i] = flag[i] && ie[i] && gie;
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  output logic [W-1:0] count,
  output logic         pwm_out,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         irq_ovf,
  output logic         irq_cmp
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      cnt_nxt, ocr_act;
  logic              step_up, adv, top_ev, bot_ev, match, dual;
  logic              wr_ctrl, wr_cnt, wr_ocr, wr_flag;
  logic [NUM_FLAGS-1:0] set_ev, clr_wr, ack_v, ie_v, flag_v, irq_v;

  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADR_CNT);
  assign wr_ocr  = wr_en && (wr_addr == ADR_OCR);
  assign wr_flag = wr_en && (wr_addr == ADR_FLAG);
  assign dual    = (ctrl_q[1:0] == MODE_DUAL);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  pwmt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .dual(dual),
    .ld(wr_cnt), .ld_val(wr_data),
    .cnt(count), .cnt_nxt(cnt_nxt), .step_up(step_up),
    .adv(adv), .top_ev(top_ev), .bot_ev(bot_ev)
  );

  pwmt_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .mode(ctrl_q[1:0]), .com(ctrl_q[3:2]),
    .wr_ocr(wr_ocr), .wr_val(wr_data), .adv(adv), .top_ev(top_ev),
    .step_up(step_up), .cnt_nxt(cnt_nxt),
    .ocr_act(ocr_act), .match(match), .pwm_out(pwm_out)
  );

  assign set_ev[FLG_OVF] = dual ? bot_ev : top_ev;
  assign set_ev[FLG_CMP] = match;
  assign clr_wr = wr_flag ? wr_data[NUM_FLAGS-1:0] : '0;
  assign ack_v  = {ack_cmp, ack_ovf};
  assign ie_v   = ctrl_q[5:4];

  pwmt_flags #(.N(NUM_FLAGS)) u_flg (
    .clk(clk), .rst(rst), .set_ev(set_ev), .clr_wr(clr_wr),
    .ack(ack_v), .ie(ie_v), .gie(ctrl_q[6]),
    .flag(flag_v), .irq(irq_v)
  );

  assign ovf_flag = flag_v[FLG_OVF];
  assign cmp_flag = flag_v[FLG_CMP];
  assign irq_ovf  = irq_v[FLG_OVF];
  assign irq_cmp  = irq_v[FLG_CMP];
endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic         pwm_out,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic         irq_ovf,
  input logic         irq_cmp,
  input logic [1:0]   mode,
  input logic [1:0]   com,
  input logic [W-1:0] ocr_act
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic ld_cnt, in_pwm;
  assign ld_cnt = wr_en && (wr_addr == 2'd1);
  assign in_pwm = (mode == 2'b01) || (mode == 2'b10);

  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !ld_cnt) |=> $stable(count));

  a_r2_slope_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !ld_cnt && mode == 2'b10) |=> (count == $past(count) + 1'b1));

  a_r3_dual_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
    ($rose(ovf_flag) && mode == 2'b01 && $past(mode) == 2'b01) |-> ($past(count) == '0));

  a_r8_steady_level: assert property (@(posedge clk) disable iff (rst)
    (in_pwm && com[1] && (ocr_act == '0 || ocr_act == TOP))
      |=> (pwm_out == (($past(ocr_act) == TOP) ^ $past(com[0]))));

  a_r11_ovf_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> ovf_flag);

  a_r11_cmp_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_cmp |-> cmp_flag);

  a_r12_counter_load: assert property (@(posedge clk) disable iff (rst)
    ld_cnt |=> (count == $past(wr_data)));
endmodule

bind pwm_timer8 pwmt_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .count(count), .pwm_out(pwm_out),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .irq_ovf(irq_ovf),
  .irq_cmp(irq_cmp), .mode(ctrl_q[1:0]), .com(ctrl_q[3:2]),
  .ocr_act(ocr_act)
);

// File: tb/sim_pwm_timer8.sv
`timescale 1ns/1ps
module sim_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ack_ovf = 1'b0;
  logic       ack_cmp = 1'b0;
  logic [7:0] count;
  logic       pwm_out, ovf_flag, cmp_flag, irq_ovf, irq_cmp;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pwm_timer8 #(.W(8)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .count(count), .pwm_out(pwm_out), .ovf_flag(ovf_flag),
    .cmp_flag(cmp_flag), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] com;
    logic [7:0] ocr;
    logic [7:0] start;
    logic [8:0] n;
    logic [7:0] ecnt;
    logic       epwm;
    logic       eovf;
    logic       ecmp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 2'b00, 8'h10, 8'hFD, 9'd4,   8'h01, 1'b0, 1'b1, 1'b0},
    '{2'b10, 2'b10, 8'h80, 8'hFE, 9'd3,   8'h01, 1'b1, 1'b1, 1'b0},
    '{2'b10, 2'b11, 8'h80, 8'h7E, 9'd3,   8'h81, 1'b1, 1'b0, 1'b1},
    '{2'b01, 2'b10, 8'h40, 8'hFE, 9'd3,   8'hFD, 1'b0, 1'b0, 1'b0},
    '{2'b01, 2'b10, 8'h40, 8'h00, 9'd2,   8'h02, 1'b0, 1'b1, 1'b0},
    '{2'b01, 2'b10, 8'h02, 8'hFF, 9'd253, 8'h02, 1'b1, 1'b0, 1'b1},
    '{2'b10, 2'b10, 8'hFF, 8'h10, 9'd5,   8'h15, 1'b1, 1'b0, 1'b0},
    '{2'b01, 2'b11, 8'h00, 8'h10, 9'd5,   8'h15, 1'b1, 1'b0, 1'b0},
    '{2'b00, 2'b01, 8'h05, 8'h03, 9'd3,   8'h06, 1'b1, 1'b0, 1'b1}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2";
      1: return "R6";
      2: return "R6";
      3: return "R3";
      4: return "R3";
      5: return "R7";
      6: return "R8";
      7: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    edge1();
    edge1();
    rst = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    edge1();
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    tick = 1'b1;
    repeat (n) edge1();
    tick = 1'b0;
  endtask

  initial begin
    #400000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    do_reset();
    edge1();
    // R1: reset state
    chk("R1 count", count, 8'h00);
    chk("R1 flags", {ovf_flag, cmp_flag}, 2'b00);
    chk("R1 irq", {irq_ovf, irq_cmp}, 2'b00);
    chk("R1 pwm", pwm_out, 1'b0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd0, 8'h00);
      wr(2'd2, TBL[i].ocr);
      wr(2'd1, TBL[i].start);
      wr(2'd0, {4'b0000, TBL[i].com, TBL[i].mode});
      run(int'(TBL[i].n));
      chk({vec_tag(i), " count"}, count, TBL[i].ecnt);
      chk({vec_tag(i), " pwm"}, pwm_out, TBL[i].epwm);
      chk({vec_tag(i), " R2/R3 overflow flag"}, ovf_flag, TBL[i].eovf);
      chk({vec_tag(i), " R4 compare flag"}, cmp_flag, TBL[i].ecmp);
    end

    // R9: compare buffering in single-slope mode
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h0A);
    wr(2'd2, 8'h20);
    run(17);
    chk("R9 count before load", count, 8'h21);
    chk("R9 no match on pending value", cmp_flag, 1'b0);
    run(223);
    chk("R6 count at wrap", count, 8'h00);
    chk("R6 pwm set at zero", pwm_out, 1'b1);
    wr(2'd3, 8'h03);
    chk("R10 write-one clears", {ovf_flag, cmp_flag}, 2'b00);
    run(31);
    chk("R9 pwm before new match", pwm_out, 1'b1);
    run(1);
    chk("R9 count at new match", count, 8'h20);
    chk("R9 pwm cleared by new value", pwm_out, 1'b0);
    chk("R9 compare flag from new value", cmp_flag, 1'b1);

    // R10: clearing and set priority
    do_reset();
    wr(2'd1, 8'hFF);
    run(1);
    chk("R10 overflow set", ovf_flag, 1'b1);
    wr(2'd3, 8'h01);
    chk("R10 overflow cleared by write", ovf_flag, 1'b0);
    wr(2'd1, 8'hFF);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h01;
    edge1();
    tick = 1'b0; wr_en = 1'b0;
    chk("R10 set wins over clear", ovf_flag, 1'b1);
    ack_ovf = 1'b1;
    edge1();
    ack_ovf = 1'b0;
    chk("R10 acknowledge clears", ovf_flag, 1'b0);

    // R11: interrupt gating
    do_reset();
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h20);
    run(1);
    chk("R11 compare flag set", cmp_flag, 1'b1);
    chk("R11 irq blocked by global enable", irq_cmp, 1'b0);
    wr(2'd0, 8'h60);
    chk("R11 irq with both enables", irq_cmp, 1'b1);
    chk("R11 overflow irq idle", irq_ovf, 1'b0);
    ack_cmp = 1'b1;
    edge1();
    ack_cmp = 1'b0;
    chk("R11 irq drops with flag", irq_cmp, 1'b0);

    // R12: load overrides tick
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h40;
    edge1();
    tick = 1'b0; wr_en = 1'b0;
    chk("R12 load beats tick", count, 8'h40);
    // R2: no tick, no change
    repeat (5) edge1();
    chk("R2 hold without tick", count, 8'h40);

    report();
  end
endmodule